// File: doc/BRIEF.md
# Crystal Clock Bring-Up Sequencer

This controller runs from the always-on internal low-speed oscillator. It brings up an external 32.768 kHz crystal, and optionally a PLL-locked main oscillator, in an order that cannot harm the CPU. It reads three configuration levels: a source choice (internal or external 32 kHz), a PLL lock request and a wait-for-stable flag. It drives control levels only: a crystal enable, the 32 kHz tree source select, a PLL enable, a CPU speed code, an application-release signal and a configuration fault flag.

The configuration is captured on the first clock edge after reset is released. With the external crystal and waiting enabled, the crystal is switched on at once. The tree stays on the low-speed oscillator until a settle counter of `SETTLE_TICKS` low-speed ticks expires. This interval is nominally one second, but it carries the full inaccuracy of the low-speed oscillator, so it can be anywhere from half to twice that. When PLL lock is requested, the PLL is enabled only after the tree switch, with the CPU held at its slowest code. After a `LOCK_TICKS` window the CPU moves to 12 MHz, and then to its final speed as the last step before release. Once released, every output holds until the next reset.

Top module: `osc_bringup_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after release before any clock edge, every output is low and the CPU speed code is 00. The codes are 00 = 3 MHz or lower, 01 = 12 MHz, 10 = final configured speed.
- R2: Configuration: internal source, no PLL request. On the first edge after reset release, `app_ready` rises and `cpu_div` becomes 10. `xtal_en` stays low.
- R3: Configuration: external source, wait flag set. `xtal_en` rises on the first edge after release. `tree_sel_xtal` stays low until exactly `SETTLE_TICKS` edges later, and then rises with no further input.
- R4: `pll_en` rises only one edge after `tree_sel_xtal` has risen. At that edge `cpu_div` is 00. `pll_en` is never high while `tree_sel_xtal` is low.
- R5: `LOCK_TICKS` edges after `pll_en` rises, `cpu_div` becomes 01. One edge later it becomes 10, and `app_ready` rises in the same edge.
- R6: Configuration: external source, wait flag set, no PLL. One edge after the tree switch, `cpu_div` becomes 10 and `app_ready` rises. `pll_en` stays low.
- R7: Configuration: internal source with a PLL request. `cfg_err` rises on the first edge. `pll_en`, `app_ready`, `xtal_en` and `tree_sel_xtal` stay low.
- R8: Configuration: external source, wait flag cleared. `xtal_en` and `app_ready` rise together on the first edge and `cpu_div` becomes 10. The tree switch and the PLL enable never occur.
- R9: The configuration inputs are sampled only on the first edge after release, so later changes have no effect on the outputs. Once `app_ready` is high, all outputs hold their values until reset.
- R10: Asserting reset in the middle of a sequence returns all outputs at once to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal low-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_src | input | 1 | 1 selects the external crystal for the 32 kHz tree |
| cfg_pll_req | input | 1 | 1 requests PLL lock of the main oscillator to the crystal |
| cfg_wait_stable | input | 1 | 1 holds release until the clocks have settled |
| xtal_en | output | 1 | Crystal oscillator enable |
| tree_sel_xtal | output | 1 | 32 kHz tree source: 0 internal, 1 crystal |
| pll_en | output | 1 | PLL enable |
| cpu_div | output | 2 | CPU speed code (00 slow, 01 12 MHz, 10 final) |
| app_ready | output | 1 | Releases the application |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
Two events can land in the same cycle. When the wait flag is cleared, the crystal enable and the application release fall on the very first edge. The bench provokes this with the external source and the wait flag low, and requires both levels after edge one. The other collision is a settle expiry against a late configuration change. The bench raises the PLL request part-way through a no-PLL settle period and checks that the settle expiry still ends in a direct release, with `pll_en` never rising.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

    typedef enum logic [2:0] {
        ST_START  = 3'd0,
        ST_SETTLE = 3'd1,
        ST_PLL_ON = 3'd2,
        ST_LOCK   = 3'd3,
        ST_FINAL  = 3'd4,
        ST_READY  = 3'd5,
        ST_FAULT  = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        CPU_SLOW  = 2'b00,
        CPU_MID   = 2'b01,
        CPU_FINAL = 2'b10
    } cpu_code_e;

    typedef struct packed {
        seq_state_e state;
        logic       xtal_en;
        logic       tree_xtal;
        logic       pll_en;
        cpu_code_e  cpu_div;
        logic       ready;
        logic       cfg_err;
        logic       use_pll;
    } seq_regs_t;

endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
    parameter int unsigned LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == LAST);
        if (!run)
            cnt_d = '0;
        else if (expire)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R3 / R5: the window counter never passes its terminal value
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3 / R5: an idle counter restarts from zero
    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/seq_cfg_decode.sv
module seq_cfg_decode (
    input  logic ext_src,
    input  logic pll_req,
    input  logic wait_stable,
    output logic bad_combo,
    output logic quick_release,
    output logic staged
);
    always_comb begin
        bad_combo     = !ext_src && pll_req;
        quick_release = !bad_combo && (!ext_src || !wait_stable);
        staged        = ext_src && wait_stable;
    end
endmodule

// File: rtl/osc_bringup_seq.sv
module osc_bringup_seq
    import osc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 32768,
    parameter int unsigned LOCK_TICKS   = 524
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_ext_src,
    input  logic       cfg_pll_req,
    input  logic       cfg_wait_stable,
    output logic       xtal_en,
    output logic       tree_sel_xtal,
    output logic       pll_en,
    output logic [1:0] cpu_div,
    output logic       app_ready,
    output logic       cfg_err
);

    localparam seq_regs_t RESET_VAL = '{
        state:     ST_START,
        xtal_en:   1'b0,
        tree_xtal: 1'b0,
        pll_en:    1'b0,
        cpu_div:   CPU_SLOW,
        ready:     1'b0,
        cfg_err:   1'b0,
        use_pll:   1'b0
    };

    seq_regs_t r_d, r_q;
    logic      bad_combo, quick_release, staged;
    logic      settle_run, settle_done, lock_run, lock_done;

    seq_cfg_decode u_cfg (
        .ext_src       (cfg_ext_src),
        .pll_req       (cfg_pll_req),
        .wait_stable   (cfg_wait_stable),
        .bad_combo     (bad_combo),
        .quick_release (quick_release),
        .staged        (staged)
    );

    assign settle_run = (r_q.state == ST_SETTLE);
    assign lock_run   = (r_q.state == ST_LOCK);

    seq_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (settle_run),
        .expire (settle_done)
    );

    seq_tick_timer #(.LIMIT(LOCK_TICKS)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (lock_run),
        .expire (lock_done)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_START: begin
                r_d.use_pll = cfg_pll_req;
                r_d.xtal_en = cfg_ext_src && !bad_combo;
                if (bad_combo) begin
                    r_d.cfg_err = 1'b1;
                    r_d.state   = ST_FAULT;
                end else if (quick_release) begin
                    r_d.ready   = 1'b1;
                    r_d.cpu_div = CPU_FINAL;
                    r_d.state   = ST_READY;
                end else if (staged) begin
                    r_d.state   = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.tree_xtal = 1'b1;
                    r_d.state     = r_q.use_pll ? ST_PLL_ON : ST_FINAL;
                end
            end
            ST_PLL_ON: begin
                r_d.cpu_div = CPU_SLOW;
                r_d.pll_en  = 1'b1;
                r_d.state   = ST_LOCK;
            end
            ST_LOCK: begin
                if (lock_done) begin
                    r_d.cpu_div = CPU_MID;
                    r_d.state   = ST_FINAL;
                end
            end
            ST_FINAL: begin
                r_d.cpu_div = CPU_FINAL;
                r_d.ready   = 1'b1;
                r_d.state   = ST_READY;
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= RESET_VAL;
        else
            r_q <= r_d;
    end

    assign xtal_en       = r_q.xtal_en;
    assign tree_sel_xtal = r_q.tree_xtal;
    assign pll_en        = r_q.pll_en;
    assign cpu_div       = r_q.cpu_div;
    assign app_ready     = r_q.ready;
    assign cfg_err       = r_q.cfg_err;

    // R4: PLL only runs on a crystal-fed tree
    assert_pll_needs_tree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> tree_sel_xtal);

    // R4: PLL turn-on happens with the CPU at the slow code, after the switch
    assert_pll_rise_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> (cpu_div == 2'b00) && $past(tree_sel_xtal));

    // R3: tree never points at a crystal that is switched off
    assert_tree_needs_xtal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tree_sel_xtal |-> xtal_en);

    // R7: fault excludes PLL and release
    assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pll_en && !app_ready && !xtal_en);

    // R9: released outputs are frozen
    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        app_ready |=> app_ready && $stable({xtal_en, tree_sel_xtal, pll_en, cpu_div, cfg_err}));

    // R5: release always comes with the final speed code
    assert_ready_speed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_ready) |-> cpu_div == 2'b10);

endmodule

// File: tb/osc_bringup_seq_tb.sv
`timescale 1ns/1ps
module osc_bringup_seq_tb;

    localparam int S   = 20;
    localparam int L   = 6;
    localparam int RUN = S + L + 6;

    // table: {ext, pll, wait}
    localparam logic [2:0] CFG_TAB [8] = '{
        3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_src = 1'b0, cfg_pll_req = 1'b0, cfg_wait_stable = 1'b0;
    logic       xtal_en, tree_sel_xtal, pll_en, app_ready, cfg_err;
    logic [1:0] cpu_div;
    logic       prev_pll;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    osc_bringup_seq #(.SETTLE_TICKS(S), .LOCK_TICKS(L)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_ext_src     (cfg_ext_src),
        .cfg_pll_req     (cfg_pll_req),
        .cfg_wait_stable (cfg_wait_stable),
        .xtal_en         (xtal_en),
        .tree_sel_xtal   (tree_sel_xtal),
        .pll_en          (pll_en),
        .cpu_div         (cpu_div),
        .app_ready       (app_ready),
        .cfg_err         (cfg_err)
    );

    // packed {xtal, tree, pll, div[1:0], ready, err} after k edges
    function automatic logic [6:0] expect_at(logic e, logic p, logic w, int k);
        logic x, t, q, r, f;
        logic [1:0] d;
        x = 0; t = 0; q = 0; r = 0; f = 0; d = 2'b00;
        if (k >= 1) begin
            if (!e && p) f = 1;
            else if (!e) begin r = 1; d = 2'b10; end
            else if (!w) begin x = 1; r = 1; d = 2'b10; end
            else begin
                x = 1;
                t = (k >= 1 + S);
                if (!p) begin
                    if (k >= 2 + S) begin r = 1; d = 2'b10; end
                end else begin
                    q = (k >= 2 + S);
                    if (k >= 3 + S + L) begin r = 1; d = 2'b10; end
                    else if (k >= 2 + S + L) d = 2'b01;
                end
            end
        end
        return {x, t, q, d, r, f};
    endfunction

    function automatic string req_of(logic e, logic p, logic w);
        if (!e && p) return "R7";
        if (!e) return "R2";
        if (!w) return "R8";
        if (!p) return "R6";
        return "R5";
    endfunction

    task automatic check_out(string req, logic [6:0] exp);
        logic [6:0] got;
        got = {xtal_en, tree_sel_xtal, pll_en, cpu_div, app_ready, cfg_err};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", req, got, exp);
        end
    endtask

    task automatic pll_guard();
        checks++;
        if (pll_en && !prev_pll && (!tree_sel_xtal || cpu_div != 2'b00)) begin
            errors++;
            $display("FAIL R4 got tree=%b div=%b exp tree=1 div=00", tree_sel_xtal, cpu_div);
        end
        prev_pll = pll_en;
    endtask

    task automatic start(logic [2:0] c);
        rst_n = 1'b0;
        {cfg_ext_src, cfg_pll_req, cfg_wait_stable} = c;
        prev_pll = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1", 7'b0);
        rst_n = 1'b1;
        #1 check_out("R1", 7'b0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // table walk
        for (int v = 0; v < 8; v++) begin
            logic [2:0] c;
            c = CFG_TAB[v];
            start(c);
            for (int k = 1; k <= RUN; k++) begin
                step();
                pll_guard();
                // R3: tree switch timing in staged runs
                check_out((c[2] && c[0] && k <= S + 1) ? "R3" : req_of(c[2], c[1], c[0]),
                          expect_at(c[2], c[1], c[0], k));
            end
            // R9: late configuration changes are ignored
            {cfg_ext_src, cfg_pll_req, cfg_wait_stable} = ~c;
            for (int k = RUN + 1; k <= RUN + 5; k++) begin
                step();
                pll_guard();
                check_out("R9", expect_at(c[2], c[1], c[0], k));
            end
        end

        // R9: PLL request raised during a no-PLL settle period
        start(3'b101);
        for (int k = 1; k <= RUN; k++) begin
            step();
            if (k == 3) cfg_pll_req = 1'b1;
            pll_guard();
            check_out("R9", expect_at(1'b1, 1'b0, 1'b1, k));
        end

        // R10: reset in the middle of the settle period
        start(3'b111);
        for (int k = 1; k <= S / 2; k++) step();
        check_out("R3", expect_at(1'b1, 1'b1, 1'b1, S / 2));
        rst_n = 1'b0;
        #1 check_out("R10", 7'b0);
        step();
        check_out("R10", 7'b0);

        // R10: reset during the PLL window, then a clean rerun
        start(3'b111);
        for (int k = 1; k <= S + 4; k++) step();
        check_out("R5", expect_at(1'b1, 1'b1, 1'b1, S + 4));
        rst_n = 1'b0;
        #1 check_out("R10", 7'b0);
        start(3'b100);
        step();
        check_out("R8", expect_at(1'b1, 1'b0, 1'b0, 1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog got hung exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule